// File: doc/BRIEF.md
# Floating-Point Status Register Update Unit

This block owns the floating-point status word of a processor's floating-point unit. After every datapath result it folds the raw IEEE exception flags into the current-exception bits. It then tests those bits against the per-exception trap enables. If an enabled exception is present, it marks the trap-type field and pulses a trap request. If not, it adds the current exceptions to the accrued-exception bits. A flag-free result leaves the word untouched.

Floating-point compares deliver a two-bit relation that is written into one of four condition-code fields chosen by the instruction. A signalling compare of unordered operands also raises the invalid exception. That exception is processed before the condition code is written. Software can load the word through a masked port, and the rounding-direction field is decoded continuously into a one-hot rounding mode for the datapath.

Top module: `fsr_update_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `fsr_q` becomes all zero and `trap_pulse` becomes 0, so `round_mode` reads 4'b0001 (nearest).
- R2: When `res_valid` is high, `exc_flags` (bit 4 invalid, 3 overflow, 2 underflow, 1 divide-by-zero, 0 inexact) is ORed into current-exception bits `fsr_q[4:0]` at the next edge. When `res_valid` is low, `exc_flags` has no effect. When the merged flags are all zero, the whole word is left unchanged.
- R3: If the merged current-exception bits ANDed with the trap-enable field `fsr_q[27:23]` (same bit order) are nonzero, bit 14 of the trap-type field `fsr_q[16:14]` is set. In that case `trap_pulse` is high for exactly the cycle in which the word shows the update.
- R4: If raised flags meet no enabled exception, the merged current-exception bits are ORed into the accrued field `fsr_q[9:5]`. If a trap is raised, the accrued field is not changed.
- R5: When `cmp_valid` is high, `cmp_rel` (00 equal, 01 less, 10 greater, 11 unordered) is written into the field chosen by `cmp_field`: 0 selects bits 11:10, 1 selects 33:32, 2 selects 35:34 and 3 selects 37:36. The other three fields are kept.
- R6: A compare with `cmp_signaling` high and relation unordered raises invalid into the exception merge of R2 to R4. A compare with `cmp_signaling` low never raises it.
- R7: A result and a compare in the same cycle are both applied. The exceptions are merged first and the condition code is written afterwards.
- R8: `round_mode` decodes `fsr_q[31:30]`: 00 gives 4'b0001 (nearest even), 01 gives 4'b0010 (toward zero), 10 gives 4'b0100 (toward +inf) and 11 gives 4'b1000 (toward -inf). Any unrecognised code gives toward zero.
- R9: When `ld_valid` is high, the bits set in `LOAD_MASK` (default 38'h3F_CF80_0FFF) take `ld_data` and all other bits keep their old value. A result or compare in the same cycle is dropped, and `trap_pulse` stays low.
- R10: `round_mode` follows the register, so after a load it shows the newly loaded direction in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | Datapath result strobe qualifying `exc_flags` |
| exc_flags | input | 5 | Raw IEEE flags {invalid, overflow, underflow, div-by-zero, inexact} |
| cmp_valid | input | 1 | Compare result strobe |
| cmp_signaling | input | 1 | Compare is the signalling kind |
| cmp_rel | input | 2 | Compare relation code |
| cmp_field | input | 2 | Condition-code field select |
| ld_valid | input | 1 | Software load strobe |
| ld_data | input | 38 | Software load value |
| fsr_q | output | 38 | Status word |
| trap_pulse | output | 1 | One-cycle trap request |
| round_mode | output | 4 | One-hot rounding mode |

## Verification
Every register update lands on the first rising edge after the stimulus is presented. `trap_pulse` is registered alongside the word, so it appears in the same cycle. `round_mode` is a combinational decode of the word, so a load reaches it at that same edge. The bench therefore drives each stimulus on a falling edge and compares all outputs with its model on the next falling edge, half a period after the update. Directed steps cover loads, traps, quiet and signalling compares and coincident events. Seeded random traffic then exercises the merge, trap and accrue paths against the same model.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int FSR_W   = 38;
    localparam int NEXC    = 5;
    localparam int CEXC_LO = 0;
    localparam int AEXC_LO = CEXC_LO + NEXC;
    localparam int CC0_LO  = 10;
    localparam int FTT_LO  = 14;
    localparam int FTT_W   = 3;
    localparam int TEM_LO  = 23;
    localparam int RD_LO   = 30;
    localparam int CCX_LO  = 32;
    localparam int NCC     = 4;
    localparam int CC_W    = 2;
    localparam int INV_BIT = NEXC - 1;

    localparam logic [FSR_W-1:0] LD_MASK_DEF = 38'h3F_CF80_0FFF;
    localparam logic [FTT_W-1:0] FTT_IEEE    = 3'b001;

    typedef enum logic [1:0] {
        REL_EQ = 2'b00,
        REL_LT = 2'b01,
        REL_GT = 2'b10,
        REL_UN = 2'b11
    } rel_e;

    typedef enum logic [3:0] {
        RM_NEAR = 4'b0001,
        RM_ZERO = 4'b0010,
        RM_UP   = 4'b0100,
        RM_DOWN = 4'b1000
    } rmode_e;

    function automatic int cc_lo(input int k);
        return (k == 0) ? CC0_LO : CCX_LO + CC_W * (k - 1);
    endfunction
endpackage

// File: rtl/fsr_exc_merge.sv
module fsr_exc_merge
    import fsr_pkg::*;
(
    input  logic [FSR_W-1:0] cur,
    input  logic [NEXC-1:0]  flags,
    output logic [FSR_W-1:0] nxt,
    output logic             trap
);
    logic [NEXC-1:0] merged;

    always_comb begin
        nxt    = cur;
        trap   = 1'b0;
        merged = cur[CEXC_LO +: NEXC] | flags;
        if (|flags) begin
            nxt[CEXC_LO +: NEXC] = merged;
            if (|(merged & cur[TEM_LO +: NEXC])) begin
                trap = 1'b1;
                nxt[FTT_LO +: FTT_W] = cur[FTT_LO +: FTT_W] | FTT_IEEE;
            end else begin
                nxt[AEXC_LO +: NEXC] = cur[AEXC_LO +: NEXC] | merged;
            end
        end
    end
endmodule

// File: rtl/fsr_cc_write.sv
module fsr_cc_write
    import fsr_pkg::*;
(
    input  logic [FSR_W-1:0] cur,
    input  logic             en,
    input  logic [1:0]       sel,
    input  rel_e             rel,
    output logic [FSR_W-1:0] nxt
);
    always_comb begin
        nxt = cur;
        for (int k = 0; k < NCC; k++) begin
            if (en && (sel == 2'(k))) begin
                nxt[cc_lo(k) +: CC_W] = rel;
            end
        end
    end
endmodule

// File: rtl/fsr_round_decode.sv
module fsr_round_decode
    import fsr_pkg::*;
(
    input  logic [1:0] rd,
    output rmode_e     rm
);
    always_comb begin
        unique case (rd)
            2'b00:   rm = RM_NEAR;
            2'b01:   rm = RM_ZERO;
            2'b10:   rm = RM_UP;
            2'b11:   rm = RM_DOWN;
            default: rm = RM_ZERO;
        endcase
    end
endmodule

// File: rtl/fsr_update_unit.sv
module fsr_update_unit
    import fsr_pkg::*;
#(
    parameter logic [FSR_W-1:0] LOAD_MASK = LD_MASK_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             res_valid,
    input  logic [NEXC-1:0]  exc_flags,
    input  logic             cmp_valid,
    input  logic             cmp_signaling,
    input  logic [1:0]       cmp_rel,
    input  logic [1:0]       cmp_field,
    input  logic             ld_valid,
    input  logic [FSR_W-1:0] ld_data,
    output logic [FSR_W-1:0] fsr_q,
    output logic             trap_pulse,
    output logic [3:0]       round_mode
);
    rel_e             rel;
    logic [NEXC-1:0]  cmp_inv;
    logic [NEXC-1:0]  flags_in;
    logic [FSR_W-1:0] after_exc;
    logic [FSR_W-1:0] after_cc;
    logic [FSR_W-1:0] ld_next;
    logic             trap_c;
    rmode_e           rm;

    assign rel      = rel_e'(cmp_rel);
    assign cmp_inv  = (cmp_valid && cmp_signaling && rel == REL_UN)
                      ? NEXC'(1 << INV_BIT) : '0;
    assign flags_in = (res_valid ? exc_flags : '0) | cmp_inv;
    assign ld_next  = (ld_data & LOAD_MASK) | (fsr_q & ~LOAD_MASK);

    fsr_exc_merge u_merge (
        .cur   (fsr_q),
        .flags (flags_in),
        .nxt   (after_exc),
        .trap  (trap_c)
    );

    fsr_cc_write u_cc (
        .cur (after_exc),
        .en  (cmp_valid),
        .sel (cmp_field),
        .rel (rel),
        .nxt (after_cc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fsr_q      <= '0;
            trap_pulse <= 1'b0;
        end else if (ld_valid) begin
            fsr_q      <= ld_next;
            trap_pulse <= 1'b0;
        end else begin
            fsr_q      <= after_cc;
            trap_pulse <= trap_c;
        end
    end

    fsr_round_decode u_rd (
        .rd (fsr_q[RD_LO +: 2]),
        .rm (rm)
    );

    assign round_mode = rm;
endmodule

// File: rtl/fsr_update_checker.sv
module fsr_update_checker
    import fsr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             res_valid,
    input logic [NEXC-1:0]  exc_flags,
    input logic             cmp_valid,
    input logic             cmp_signaling,
    input logic [1:0]       cmp_rel,
    input logic [1:0]       cmp_field,
    input logic             ld_valid,
    input logic [FSR_W-1:0] fsr_q,
    input logic             trap_pulse,
    input logic [3:0]       round_mode
);
    a_r2_flags_held: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !ld_valid) |=>
        ((fsr_q[CEXC_LO +: NEXC] & $past(exc_flags)) == $past(exc_flags)));

    a_r3_trap_marks_type: assert property (@(posedge clk) disable iff (rst)
        trap_pulse |-> fsr_q[FTT_LO]);

    a_r3_trap_has_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(trap_pulse) |-> ($past(res_valid || cmp_valid) && !$past(ld_valid)));

    a_r4_accrue: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !ld_valid) |=>
        (trap_pulse || ((fsr_q[AEXC_LO +: NEXC] & $past(exc_flags)) == $past(exc_flags))));

    a_r5_cc0_written: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && !ld_valid && cmp_field == 2'd0) |=>
        (fsr_q[CC0_LO +: CC_W] == $past(cmp_rel)));

    a_r6_signal_invalid: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_signaling && cmp_rel == 2'b11 && !ld_valid) |=>
        fsr_q[CEXC_LO + INV_BIT]);

    a_r2_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!res_valid && !cmp_valid && !ld_valid) |=> $stable(fsr_q));

    a_r8_mode_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(round_mode) == 1);
endmodule

bind fsr_update_unit fsr_update_checker i_chk (.*);

// File: tb/test_fsr_update_unit.sv
`timescale 1ns/1ps
module test_fsr_update_unit;
    localparam logic [37:0] MASK = 38'h3F_CF80_0FFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        res_valid = 0, cmp_valid = 0, cmp_signaling = 0, ld_valid = 0;
    logic [4:0]  exc_flags = 0;
    logic [1:0]  cmp_rel = 0, cmp_field = 0;
    logic [37:0] ld_data = 0;
    logic [37:0] fsr_q;
    logic        trap_pulse;
    logic [3:0]  round_mode;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [37:0] exp_fsr = '0;
    logic        exp_trap = 1'b0;

    always #4 clk = ~clk;

    fsr_update_unit i_fsr_update_unit (.*);

    function automatic logic [38:0] model(input logic [37:0] f, input logic rv,
        input logic [4:0] fl, input logic cv, input logic cs, input logic [1:0] cr,
        input logic [1:0] cf, input logic lv, input logic [37:0] ld);
        logic [37:0] n;
        logic [4:0]  e;
        logic        t;
        if (lv) return {1'b0, (ld & MASK) | (f & ~MASK)};
        n = f; t = 1'b0;
        e = rv ? fl : 5'd0;
        if (cv && cs && cr == 2'b11) e[4] = 1'b1;
        if (e != 0) begin
            n[4:0] = n[4:0] | e;
            if ((n[4:0] & f[27:23]) != 0) begin t = 1'b1; n[14] = 1'b1; end
            else n[9:5] = n[9:5] | n[4:0];
        end
        if (cv) begin
            case (cf)
                2'd0: n[11:10] = cr;
                2'd1: n[33:32] = cr;
                2'd2: n[35:34] = cr;
                default: n[37:36] = cr;
            endcase
        end
        return {t, n};
    endfunction

    function automatic logic [3:0] exp_rm(input logic [1:0] rd);
        case (rd)
            2'b00: return 4'b0001;
            2'b01: return 4'b0010;
            2'b10: return 4'b0100;
            default: return 4'b1000;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check("R2 cexc", fsr_q[4:0], exp_fsr[4:0]);
        check("R4 aexc", fsr_q[9:5], exp_fsr[9:5]);
        check("R3 trap", {fsr_q[16:14], trap_pulse}, {exp_fsr[16:14], exp_trap});
        check("R5 cc", {fsr_q[37:32], fsr_q[11:10]}, {exp_fsr[37:32], exp_fsr[11:10]});
        check("R8 rmode", round_mode, exp_rm(exp_fsr[31:30]));
        check(tag, fsr_q, exp_fsr);
    endtask

    task automatic step(input string tag, input logic rv, input logic [4:0] fl,
        input logic cv, input logic cs, input logic [1:0] cr, input logic [1:0] cf,
        input logic lv, input logic [37:0] ld);
        res_valid = rv; exc_flags = fl; cmp_valid = cv; cmp_signaling = cs;
        cmp_rel = cr; cmp_field = cf; ld_valid = lv; ld_data = ld;
        {exp_trap, exp_fsr} = model(exp_fsr, rv, fl, cv, cs, cr, cf, lv, ld);
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check("R1 reset word", fsr_q, 38'd0);
        check("R1 reset trap", trap_pulse, 1'b0);
        check("R1 reset rmode", round_mode, 4'b0001);
        rst = 1'b0;
        step("R2", 1, 5'b00001, 0, 0, 0, 0, 0, 0);
        step("R2 ignored", 0, 5'b11111, 0, 0, 0, 0, 0, 0);
        step("R2 zero flags", 1, 5'b00000, 0, 0, 0, 0, 0, 0);
        step("R9 load", 0, 0, 0, 0, 0, 0, 1, 38'h00_8400_0000);
        step("R10 rmode after load", 0, 0, 0, 0, 0, 0, 0, 0);
        step("R3 trap", 1, 5'b01000, 0, 0, 0, 0, 0, 0);
        step("R3 pulse ends", 0, 0, 0, 0, 0, 0, 0, 0);
        step("R9 clear", 0, 0, 0, 0, 0, 0, 1, 38'h00_4000_0000);
        step("R6 quiet", 0, 0, 1, 0, 2'b11, 2'd2, 0, 0);
        step("R6 signalling", 0, 0, 1, 1, 2'b11, 2'd3, 0, 0);
        step("R7 both", 1, 5'b00100, 1, 0, 2'b01, 2'd1, 0, 0);
        step("R5 field0", 0, 0, 1, 0, 2'b10, 2'd0, 0, 0);
        step("R9 load wins", 1, 5'b11111, 1, 1, 2'b11, 2'd0, 1, 38'h3F_FFFF_FFFF);
        step("R10 down", 0, 0, 0, 0, 0, 0, 0, 0);
        step("R9 zero", 0, 0, 0, 0, 0, 0, 1, 38'd0);
        for (int i = 0; i < 3000; i++) begin
            logic lv;
            logic [37:0] ld;
            lv = ($urandom_range(0, 15) == 0);
            ld = {$urandom(), $urandom()};
            if ($urandom_range(0, 1) == 0) ld[27:23] = 5'd0;
            step("R7 random", $urandom_range(0, 1), 5'($urandom_range(0, 3) == 0 ? $urandom() : 0),
                 $urandom_range(0, 1), $urandom_range(0, 1), 2'($urandom()), 2'($urandom()),
                 lv, ld);
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule